// File: doc/BRIEF.md
# Serial Flash Sector Lock Controller

This block is the slave-side command handler for the sector lock registers of a serial flash device. It watches a single-bit serial data input framed by an active-low chip select. It acts on two commands: one that arms a write-enable latch, and one that writes a sector's volatile lock bits. Each sector has two lock bits. The write-lock bit protects the sector. The lock-down bit freezes both lock bits of that sector until the next reset. The whole flash array, the program and erase engines, and the read paths are outside the block. A single `busy` input stands in for a program or erase cycle that is in progress.

The serial clock and chip select are sampled on the system clock and are assumed to be already synchronous to it. A rising serial-clock edge sampled while chip select is low shifts one bit in, MSB first. A lock write consists of the opcode, the address bytes (three, or four when `addr4_en` is high at the opcode) and one data byte. The write commits only if chip select rises exactly after the eighth data bit. The lock bits of every sector are exposed as output vectors.

Top module: `spi_lock_ctrl`

## Requirements
- R1: After reset every write-lock bit, every lock-down bit and the write-enable latch `wel` are 0.
- R2: A frame holding only the write-enable opcode (default 0x06), with chip select rising right after its eighth bit, sets `wel`.
- R3: A lock-write frame (opcode default 0xE5) has the form opcode, address bytes, data byte. If chip select rises right after the eighth data bit while `wel` is 1, data bit 0 is loaded into the addressed sector's write-lock bit and data bit 1 into its lock-down bit. All other sectors stay unchanged.
- R4: A lock-write frame that arrives while `wel` is 0 changes no lock bit.
- R5: A lock-write frame is discarded, with no change to the lock bits and none to `wel`, if chip select rises before the data byte is complete or after any bit beyond it.
- R6: A lock-write frame that ends while `busy` is 1 is rejected with no change to the lock bits or `wel`.
- R7: A committed lock write clears `wel`.
- R8: The sector index is address bits 19:16 (64 KB sectors, 16 sectors). Any address inside a sector selects that sector.
- R9: If `addr4_en` is 1 when the opcode completes, the frame carries four address bytes (32-bit address). The sector index is still bits 19:16.
- R10: Once a sector's lock-down bit is 1, later lock writes to that sector leave both of its bits unchanged until reset.
- R11: A frame whose first byte is neither opcode is ignored to its end and changes no state. Data bits 7:2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; bits shift in on its rising edge |
| mosi | input | 1 | Serial data input, MSB first |
| busy | input | 1 | Program or erase cycle in progress |
| addr4_en | input | 1 | Selects a 4-byte address |
| wel | output | 1 | Write-enable latch |
| wlock_vec | output | 16 | Write-lock bit for each sector |
| ldown_vec | output | 16 | Lock-down bit for each sector |

## Verification
The bench aims at the framing edges: chip select rising four bits into the data byte and one bit past it. A design that counts loosely would commit the truncated or overrun data in those cases, or would drop `wel` without writing. A write that ends under `busy` checks that the latch survives, because a design that clears `wel` on any attempted write would fail the retry that follows. Writing a locked-down sector and sending an unknown opcode followed by a valid-looking lock write catch a sticky bit that was never frozen and a decoder that resynchronises inside a frame. A 4-byte address with non-zero upper bits catches a design that takes the sector index from the wrong byte.

// File: rtl/spi_lock_pkg.sv
package spi_lock_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_ARMED,
        ST_WREN,
        ST_SKIP
    } dec_state_e;

    typedef struct packed {
        logic ldown;
        logic wlock;
    } lock_bits_t;

    localparam int BYTE_W = 8;

    function automatic lock_bits_t lock_from_byte(input logic [BYTE_W-1:0] b);
        lock_bits_t r;
        r.wlock = b[0];
        r.ldown = b[1];
        return r;
    endfunction

endpackage

// File: rtl/spi_lock_shifter.sv
module spi_lock_shifter
    import spi_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              bit_stb,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_out,
    output logic              frame_end
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_q, cs_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;

    assign bit_stb   = sck && !sck_q && !cs_n;
    assign byte_stb  = bit_stb && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign byte_out  = {shreg, mosi};
    assign frame_end = cs_n && !cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (bit_stb) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[BYTE_W-3:0], mosi};
            end
        end
    end

    // bit alignment restarts with every frame
    p_frame_realign_r5: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_lock_decoder.sv
module spi_lock_decoder
    import spi_lock_pkg::*;
#(
    parameter logic [7:0] OP_WREN  = 8'h06,
    parameter logic [7:0] OP_WRLR  = 8'hE5,
    parameter int         SECT_LSB = 16,
    parameter int         SECT_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              frame_end,
    input  logic              busy,
    input  logic              addr4_en,
    output logic              wel,
    output logic              wr_en,
    output logic [SECT_W-1:0] wr_sect,
    output lock_bits_t        wr_bits
);
    localparam int ADDR_W = 4 * BYTE_W;

    dec_state_e        state;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        acnt;
    logic              four;
    logic [BYTE_W-1:0] data;

    assign wr_en   = frame_end && (state == ST_ARMED) && wel && !busy;
    assign wr_sect = addr[SECT_LSB +: SECT_W];
    assign wr_bits = lock_from_byte(data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OPC;
            wel   <= 1'b0;
            addr  <= '0;
            acnt  <= '0;
            four  <= 1'b0;
            data  <= '0;
        end else if (frame_end) begin
            state <= ST_OPC;
            addr  <= '0;
            if (state == ST_WREN) wel <= 1'b1;
            else if (wr_en)       wel <= 1'b0;
        end else if (bit_stb) begin
            unique case (state)
                ST_OPC: if (byte_stb) begin
                    if (byte_in == OP_WREN) begin
                        state <= ST_WREN;
                    end else if (byte_in == OP_WRLR) begin
                        state <= ST_ADDR;
                        acnt  <= '0;
                        four  <= addr4_en;
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_ADDR: if (byte_stb) begin
                    addr <= {addr[ADDR_W-BYTE_W-1:0], byte_in};
                    acnt <= acnt + 1'b1;
                    if (acnt == (four ? 2'd3 : 2'd2)) state <= ST_DATA;
                end
                ST_DATA: if (byte_stb) begin
                    data  <= byte_in;
                    state <= ST_ARMED;
                end
                ST_ARMED, ST_WREN: state <= ST_SKIP;
                default: state <= ST_SKIP;
            endcase
        end
    end

    p_wel_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wel);

    p_wel_source_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(state == ST_WREN));

endmodule

// File: rtl/spi_lock_store.sv
module spi_lock_store
    import spi_lock_pkg::*;
#(
    parameter int SECT_W = 4,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] wr_sect,
    input  lock_bits_t        wr_bits,
    output logic [NSECT-1:0]  wlock_vec,
    output logic [NSECT-1:0]  ldown_vec
);
    logic [NSECT-1:0] sel;

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        assign sel[i] = wr_en && (wr_sect == SECT_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                wlock_vec[i] <= 1'b0;
                ldown_vec[i] <= 1'b0;
            end else if (sel[i] && !ldown_vec[i]) begin
                wlock_vec[i] <= wr_bits.wlock;
                ldown_vec[i] <= wr_bits.ldown;
            end
        end

        p_ldown_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            ldown_vec[i] |=> (ldown_vec[i] && $stable(wlock_vec[i])));
    end

    p_one_sector_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/spi_lock_ctrl.sv
module spi_lock_ctrl
    import spi_lock_pkg::*;
#(
    parameter logic [7:0] OP_WREN  = 8'h06,
    parameter logic [7:0] OP_WRLR  = 8'hE5,
    parameter int         SECT_LSB = 16,
    parameter int         SECT_W   = 4,
    localparam int        NSECT    = 1 << SECT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             busy,
    input  logic             addr4_en,
    output logic             wel,
    output logic [NSECT-1:0] wlock_vec,
    output logic [NSECT-1:0] ldown_vec
);
    logic              bit_stb, byte_stb, frame_end, wr_en;
    logic [BYTE_W-1:0] byte_v;
    logic [SECT_W-1:0] wr_sect;
    lock_bits_t        wr_bits;

    spi_lock_shifter u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .bit_stb(bit_stb), .byte_stb(byte_stb), .byte_out(byte_v),
        .frame_end(frame_end)
    );

    spi_lock_decoder #(
        .OP_WREN(OP_WREN), .OP_WRLR(OP_WRLR),
        .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)
    ) u_dec (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .byte_stb(byte_stb),
        .byte_in(byte_v), .frame_end(frame_end), .busy(busy),
        .addr4_en(addr4_en), .wel(wel), .wr_en(wr_en),
        .wr_sect(wr_sect), .wr_bits(wr_bits)
    );

    spi_lock_store #(.SECT_W(SECT_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sect(wr_sect),
        .wr_bits(wr_bits), .wlock_vec(wlock_vec), .ldown_vec(ldown_vec)
    );

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(wlock_vec) && $stable(ldown_vec)));

    p_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
        !wel |=> ($stable(wlock_vec) && $stable(ldown_vec)));

endmodule

// File: tb/sim_spi_lock_ctrl.sv
module sim_spi_lock_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0, addr4_en = 1'b0;
    logic        wel;
    logic [15:0] wlock_vec, ldown_vec;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [15:0] m_wl = '0, m_ld = '0;
    logic        m_wel = 1'b0;

    always #4 clk = ~clk;

    spi_lock_ctrl u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .busy(busy), .addr4_en(addr4_en), .wel(wel),
        .wlock_vec(wlock_vec), .ldown_vec(ldown_vec)
    );

    // addr[23:0] in bits 31:8, data byte in bits 7:0
    localparam logic [31:0] VEC [7] = '{
        32'h03000001, 32'h03FFFF00, 32'h0FFFFFFD, 32'h00000001,
        32'h07ABCD03, 32'h07000000, 32'h0A123402
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d exp<150000", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " wlock"}, {16'h0, wlock_vec}, {16'h0, m_wl});
        check({req, " ldown"}, {16'h0, ldown_vec}, {16'h0, m_ld});
        check({req, " wel"},   {31'h0, wel},       {31'h0, m_wel});
    endtask

    task automatic send_bit(input logic b);
        mosi = b;
        sck  = 1'b0;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic begin_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_frame();
        sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wren();
        begin_frame();
        send_byte(8'h06);
        end_frame();
        m_wel = 1'b1;
    endtask

    task automatic wrlr_body(input logic [31:0] a, input logic four);
        send_byte(8'hE5);
        if (four) send_byte(a[31:24]);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
    endtask

    task automatic wrlr(input logic [31:0] a, input logic [7:0] d, input logic four);
        begin_frame();
        wrlr_body(a, four);
        send_byte(d);
        end_frame();
        if (m_wel && !busy) begin
            if (!m_ld[a[19:16]]) begin
                m_wl[a[19:16]] = d[0];
                m_ld[a[19:16]] = d[1];
            end
            m_wel = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // table walk: R2 set, R3/R8 write, R7 clear, R10 lock-down, R11 reserved bits
        foreach (VEC[k]) begin
            wren();
            check("R2 wel set", {31'h0, wel}, 32'h1);
            wrlr({8'h00, VEC[k][31:8]}, VEC[k][7:0], 1'b0);
            check_all($sformatf("R3 R7 R8 R10 vec%0d", k));
        end

        // R4: no write enable
        wrlr(32'h00020000, 8'h01, 1'b0);
        check_all("R4 no wel");

        // R5: chip select rises four bits into data byte
        wren();
        begin_frame();
        wrlr_body(32'h00020000, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_frame();
        check_all("R5 short");

        // R5: one bit past the data byte
        begin_frame();
        wrlr_body(32'h00020000, 1'b0);
        send_byte(8'h01);
        send_bit(1'b0);
        end_frame();
        check_all("R5 long");

        // R6: busy at frame end rejects, latch kept
        busy = 1'b1;
        wrlr(32'h00020000, 8'h01, 1'b0);
        busy = 1'b0;
        @(negedge clk);
        check_all("R6 busy");
        wrlr(32'h00020000, 8'h01, 1'b0);
        check_all("R6 retry");

        // R9: four-byte address, upper byte non-zero
        addr4_en = 1'b1;
        wren();
        wrlr(32'hAB051234, 8'h01, 1'b1);
        addr4_en = 1'b0;
        check_all("R9 addr4");

        // R11: unknown opcode followed by a valid-looking body
        wren();
        begin_frame();
        send_byte(8'h9F);
        send_byte(8'hE5);
        send_byte(8'h0C);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h01);
        end_frame();
        check_all("R11 unknown op");

        // R1/R10: reset frees locked-down sectors
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_wl = '0; m_ld = '0; m_wel = 1'b0;
        @(negedge clk);
        check_all("R1 R10 rereset");

        summary();
    end
endmodule